// File: doc/BRIEF.md
# Load-Use Interlock and Replay Unit

This unit sits in the decode and register-fetch stage of an eight-stage in-order integer pipeline. The stages, in order, are IF, IS, RF, EX, DF, DS, TC and WB. The unit keeps its own copy of which instruction slots in EX, DF, DS and TC hold loads, and which register each load writes. Every cycle it compares both source register indices of the instruction now in RF against the destinations of the loads in EX, DF and DS.

Load data first becomes usable at the end of DS. A consumer that reaches RF too early is therefore held there: the fetch and decode stages freeze, and a bubble goes into EX until the data can be forwarded. Whether the data-cache access actually hit is only known one stage later, in TC. A consumer that took the early value is therefore speculative while its load sits in TC. If TC then reports a miss, the unit freezes the whole pipeline until the refill completes. After that it signals the consumer in EX to execute again with the refilled data. While the hit is unconfirmed, it flags that consumer so that no register write or store commit takes effect.

Top module: `load_use_replay`

## Requirements
- R1: After reset, with no instruction presented, stall_rf, bubble_ex, fwd_a, fwd_b, freeze_all, ex_unsafe and replay_ex are all low.
- R2: If an instruction reads, on either source, the nonzero destination of a load issued in the cycle just before it, stall_rf and bubble_ex are high for exactly two cycles. In the third cycle stall_rf is low and the matching fwd flag is high.
- R3: If one instruction separates the load from its consumer, stall_rf is high for one cycle only. Whatever the pattern, stall_rf is never high in three consecutive cycles.
- R4: If the load is in DS while its consumer is in RF, there is no stall, and fwd_a (source A) or fwd_b (source B) marks which source takes the early load data. With three or more instructions between the load and its consumer, there is neither a stall nor a fwd flag.
- R5: Register index 0 is never a dependency, and an instruction that is not a load never causes a stall.
- R6: A miss (tc_hit low while a load is in TC) raises freeze_all in that same cycle. freeze_all stays high until the cycle in which refill_done is seen during the refill. It drops in the next cycle.
- R7: In the cycle after refill_done is accepted, replay_ex pulses for one cycle if EX holds a consumer that took the early data of the missed load.
- R8: ex_unsafe is high only while EX holds a consumer of early load data whose hit is not yet confirmed. It is low in a cycle where tc_hit confirms the hit, and it never rises without freeze_all.
- R9: A miss on a load that has no early consumer still freezes the pipeline until refill_done, but replay_ex stays low.
- R10: While frozen, no stage advances and stall_rf is low. After release, the interlock resumes with the stall cycles that were still owed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| rf_vld | input | 1 | RF holds a valid instruction |
| rf_is_load | input | 1 | The RF instruction is a load |
| rf_dst | input | REG_W | Destination register of the RF instruction |
| rf_src_a | input | REG_W | First source register of the RF instruction |
| rf_src_b | input | REG_W | Second source register of the RF instruction |
| tc_hit | input | 1 | Data-cache hit result for the load in TC |
| refill_done | input | 1 | One-cycle pulse when the missed line is refilled |
| stall_rf | output | 1 | Hold IF, IS and RF this cycle |
| bubble_ex | output | 1 | Insert a bubble into EX this cycle |
| fwd_a | output | 1 | Source A takes the load data leaving DS |
| fwd_b | output | 1 | Source B takes the load data leaving DS |
| freeze_all | output | 1 | Freeze every stage (miss pending) |
| ex_unsafe | output | 1 | EX consumer's load hit unconfirmed; block destructive updates |
| replay_ex | output | 1 | EX consumer re-executes with refilled data |

## Verification
The properties assume three things about the inputs:
- The front end keeps the same instruction in RF while stall_rf or freeze_all is high.
- tc_hit matters only while a load is in TC.
- refill_done is meaningful only during a refill.

The random stimulus keeps to all three. It holds its current RF instruction whenever its model predicts a stall or freeze. It draws tc_hit freely, because the unit ignores it outside a pending TC load. It pulses refill_done at random, and a pulse that arrives in the miss cycle itself is expected to be ignored. Register indices come from a narrow range, so back-to-back dependencies and index-0 sources occur often.

// File: rtl/llu_pkg.sv
package llu_pkg;
   // Tracked slots: 0=EX, 1=DF, 2=DS, 3=TC (order is behaviour)
   localparam int unsigned LLU_NSTG  = 4;
   localparam int unsigned LLU_NCMP  = LLU_NSTG - 1;
   localparam int unsigned LLU_NSRC  = 2;
   localparam int unsigned LLU_EX    = 0;
   localparam int unsigned LLU_DF    = 1;
   localparam int unsigned LLU_DS    = 2;
   localparam int unsigned LLU_TC    = 3;

   typedef enum logic [0:0] {
      LLU_RUN    = 1'b0,
      LLU_REFILL = 1'b1
   } llu_state_e;
endpackage

// File: rtl/llu_cmp.sv
module llu_cmp #(
   parameter int unsigned REG_W     = 5,
   parameter int unsigned NCMP      = 3,
   parameter bit          ZERO_NULL = 1'b1
) (
   input  logic [NCMP-1:0]            st_vld,
   input  logic [NCMP-1:0]            st_load,
   input  logic [NCMP-1:0][REG_W-1:0] st_dst,
   input  logic [REG_W-1:0]           src,
   output logic [NCMP-1:0]            hit
);
   logic src_ok;

   generate
      if (ZERO_NULL) begin : g_zero_null
         assign src_ok = |src;
      end else begin : g_zero_real
         assign src_ok = 1'b1;
      end
   endgenerate

   generate
      for (genvar g = 0; g < NCMP; g++) begin : g_stage
         assign hit[g] = src_ok & st_vld[g] & st_load[g] & (st_dst[g] == src);
      end
   endgenerate
endmodule

// File: rtl/llu_track.sv
module llu_track
   import llu_pkg::*;
#(
   parameter int unsigned REG_W = 5
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           advance,
   input  logic                           bubble,
   input  logic                           rf_vld,
   input  logic                           rf_is_load,
   input  logic [REG_W-1:0]               rf_dst,
   input  logic                           rf_spec,
   input  logic                           confirm_set,
   output logic [LLU_NSTG-1:0]            st_vld,
   output logic [LLU_NSTG-1:0]            st_load,
   output logic [LLU_NCMP-1:0][REG_W-1:0] st_dst,
   output logic                           ex_spec,
   output logic                           tc_ok
);
   logic entry_vld;

   assign entry_vld = rf_vld & ~bubble;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_vld  <= '0;
         st_load <= '0;
         st_dst  <= '0;
         ex_spec <= 1'b0;
         tc_ok   <= 1'b0;
      end else if (advance) begin
         st_vld[LLU_EX]  <= entry_vld;
         st_load[LLU_EX] <= entry_vld & rf_is_load;
         st_dst[LLU_EX]  <= rf_dst;
         ex_spec         <= entry_vld & rf_spec;
         for (int i = 1; i < LLU_NSTG; i++) begin
            st_vld[i]  <= st_vld[i-1];
            st_load[i] <= st_load[i-1];
         end
         for (int i = 1; i < LLU_NCMP; i++) begin
            st_dst[i] <= st_dst[i-1];
         end
         tc_ok <= 1'b0;
      end else if (confirm_set) begin
         tc_ok <= 1'b1;
      end
   end
endmodule

// File: rtl/llu_miss.sv
module llu_miss
   import llu_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic tc_pend,
   input  logic tc_hit,
   input  logic refill_done,
   output logic freeze,
   output logic hit_now,
   output logic refill_ack,
   output logic replay_q
);
   llu_state_e state_q, state_d;
   logic       miss_now;

   assign miss_now   = (state_q == LLU_RUN) & tc_pend & ~tc_hit;
   assign freeze     = miss_now | (state_q == LLU_REFILL);
   assign hit_now    = (state_q == LLU_RUN) & tc_hit;
   assign refill_ack = (state_q == LLU_REFILL) & refill_done;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         LLU_RUN:    if (miss_now)    state_d = LLU_REFILL;
         LLU_REFILL: if (refill_done) state_d = LLU_RUN;
         default:                     state_d = LLU_RUN;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q  <= LLU_RUN;
         replay_q <= 1'b0;
      end else begin
         state_q  <= state_d;
         replay_q <= refill_ack;
      end
   end
endmodule

// File: rtl/load_use_replay.sv
module load_use_replay
   import llu_pkg::*;
#(
   parameter int unsigned REG_W     = 5,
   parameter bit          ZERO_NULL = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rf_vld,
   input  logic             rf_is_load,
   input  logic [REG_W-1:0] rf_dst,
   input  logic [REG_W-1:0] rf_src_a,
   input  logic [REG_W-1:0] rf_src_b,
   input  logic             tc_hit,
   input  logic             refill_done,
   output logic             stall_rf,
   output logic             bubble_ex,
   output logic             fwd_a,
   output logic             fwd_b,
   output logic             freeze_all,
   output logic             ex_unsafe,
   output logic             replay_ex
);
   generate
      if (REG_W < 2) begin : g_bad_width
         $error("load_use_replay: REG_W must be at least 2");
      end
      if (LLU_NCMP != LLU_DS + 1) begin : g_bad_depth
         $error("load_use_replay: compare depth must end at DS");
      end
   endgenerate

   logic [LLU_NSTG-1:0]            st_vld, st_load;
   logic [LLU_NCMP-1:0][REG_W-1:0] st_dst;
   logic                           ex_spec, tc_ok;
   logic [LLU_NSRC-1:0][REG_W-1:0] srcs;
   logic [LLU_NSRC-1:0][LLU_NCMP-1:0] hits;
   logic [LLU_NSRC-1:0]            early, ds_hit;
   logic                           hazard, tc_pend, confirm;
   logic                           hit_now, refill_ack, replay_q;

   assign srcs[0] = rf_src_a;
   assign srcs[1] = rf_src_b;

   generate
      for (genvar s = 0; s < LLU_NSRC; s++) begin : g_src
         llu_cmp #(
            .REG_W    (REG_W),
            .NCMP     (LLU_NCMP),
            .ZERO_NULL(ZERO_NULL)
         ) u_cmp (
            .st_vld (st_vld[LLU_NCMP-1:0]),
            .st_load(st_load[LLU_NCMP-1:0]),
            .st_dst (st_dst),
            .src    (srcs[s]),
            .hit    (hits[s])
         );
         assign early[s]  = hits[s][LLU_EX] | hits[s][LLU_DF];
         assign ds_hit[s] = rf_vld & hits[s][LLU_DS];
      end
   endgenerate

   assign hazard    = rf_vld & (|early);
   assign stall_rf  = hazard & ~freeze_all;
   assign bubble_ex = stall_rf;
   assign fwd_a     = ds_hit[0];
   assign fwd_b     = ds_hit[1];

   assign tc_pend   = st_vld[LLU_TC] & st_load[LLU_TC] & ~tc_ok;
   assign confirm   = tc_ok | hit_now;
   assign ex_unsafe = st_vld[LLU_EX] & ex_spec & ~confirm;
   assign replay_ex = replay_q & st_vld[LLU_EX] & ex_spec;

   llu_track #(.REG_W(REG_W)) u_track (
      .clk        (clk),
      .rst_n      (rst_n),
      .advance    (~freeze_all),
      .bubble     (stall_rf),
      .rf_vld     (rf_vld),
      .rf_is_load (rf_is_load),
      .rf_dst     (rf_dst),
      .rf_spec    (|ds_hit),
      .confirm_set(refill_ack),
      .st_vld     (st_vld),
      .st_load    (st_load),
      .st_dst     (st_dst),
      .ex_spec    (ex_spec),
      .tc_ok      (tc_ok)
   );

   llu_miss u_miss (
      .clk        (clk),
      .rst_n      (rst_n),
      .tc_pend    (tc_pend),
      .tc_hit     (tc_hit),
      .refill_done(refill_done),
      .freeze     (freeze_all),
      .hit_now    (hit_now),
      .refill_ack (refill_ack),
      .replay_q   (replay_q)
   );
endmodule

// File: rtl/llu_chk.sv
module llu_chk #(
   parameter int unsigned REG_W = 5
) (
   input logic             clk,
   input logic             rst_n,
   input logic             rf_vld,
   input logic             rf_is_load,
   input logic [REG_W-1:0] rf_dst,
   input logic [REG_W-1:0] rf_src_a,
   input logic             refill_done,
   input logic             stall_rf,
   input logic             freeze_all,
   input logic             ex_unsafe,
   input logic             replay_ex
);
   // R2
   load_use_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rf_vld && rf_is_load && rf_dst != '0 && !stall_rf && !freeze_all) ##1
      (rf_vld && rf_src_a == $past(rf_dst) && !freeze_all) |-> stall_rf);

   // R3
   stall_max_two_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (stall_rf && $past(stall_rf)) |=> !stall_rf);

   // R6
   miss_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (freeze_all && !refill_done) |=> freeze_all);

   // R7
   replay_after_refill_chk: assert property (@(posedge clk) disable iff (!rst_n)
      replay_ex |-> ($past(freeze_all) && !freeze_all));

   // R8
   commit_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ex_unsafe |-> freeze_all);

   // R10
   freeze_no_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      freeze_all |-> !stall_rf);
endmodule

bind load_use_replay llu_chk #(.REG_W(REG_W)) u_llu_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .rf_vld     (rf_vld),
   .rf_is_load (rf_is_load),
   .rf_dst     (rf_dst),
   .rf_src_a   (rf_src_a),
   .refill_done(refill_done),
   .stall_rf   (stall_rf),
   .freeze_all (freeze_all),
   .ex_unsafe  (ex_unsafe),
   .replay_ex  (replay_ex)
);

// File: tb/load_use_replay_bench.sv
module load_use_replay_bench;
   localparam int CLK_PERIOD = 10;
   localparam int REG_W      = 5;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             rf_vld = 1'b0, rf_is_load = 1'b0, tc_hit = 1'b0, refill_done = 1'b0;
   logic [REG_W-1:0] rf_dst = '0, rf_src_a = '0, rf_src_b = '0;
   logic             stall_rf, bubble_ex, fwd_a, fwd_b, freeze_all, ex_unsafe, replay_ex;

   int n_chk = 0;
   int n_err = 0;

   // Bench model of the tracked slots: 0=EX 1=DF 2=DS 3=TC
   bit m_vld[4], m_ld[4];
   int m_dst[3];
   bit m_spec, m_ok, m_refill, m_rep;
   // Expected outputs of the current cycle
   bit e_stall, e_fa, e_fb, e_frz, e_uns, e_rep;

   always #(CLK_PERIOD/2) clk = ~clk;

   load_use_replay #(.REG_W(REG_W)) u_load_use_replay (
      .clk(clk), .rst_n(rst_n), .rf_vld(rf_vld), .rf_is_load(rf_is_load),
      .rf_dst(rf_dst), .rf_src_a(rf_src_a), .rf_src_b(rf_src_b),
      .tc_hit(tc_hit), .refill_done(refill_done),
      .stall_rf(stall_rf), .bubble_ex(bubble_ex), .fwd_a(fwd_a), .fwd_b(fwd_b),
      .freeze_all(freeze_all), .ex_unsafe(ex_unsafe), .replay_ex(replay_ex)
   );

   task automatic chk(input bit got, input bit exp, input string req, input string what);
      n_chk++;
      if (got !== exp) begin
         n_err++;
         $display("FAIL %s %s actual %0b expected %0b at %0t", req, what, got, exp, $time);
      end
   endtask

   function automatic bit dep(input int i, input int src);
      return src != 0 && m_vld[i] && m_ld[i] && m_dst[i] == src;
   endfunction

   task automatic model_reset();
      for (int i = 0; i < 4; i++) begin m_vld[i] = 0; m_ld[i] = 0; end
      for (int i = 0; i < 3; i++) m_dst[i] = 0;
      m_spec = 0; m_ok = 0; m_refill = 0; m_rep = 0;
   endtask

   // One cycle: drive, predict, compare, then advance the model to the next edge
   task automatic step(input bit v, input bit ld, input int dst, input int a, input int b,
                       input bit hit, input bit rd);
      bit hz, pend, miss, conf;
      @(negedge clk);
      rf_vld = v; rf_is_load = ld; rf_dst = dst[REG_W-1:0];
      rf_src_a = a[REG_W-1:0]; rf_src_b = b[REG_W-1:0];
      tc_hit = hit; refill_done = rd;
      #1;
      hz      = v && (dep(0, a) || dep(1, a) || dep(0, b) || dep(1, b));
      pend    = m_vld[3] && m_ld[3] && !m_ok;
      miss    = !m_refill && pend && !hit;
      e_frz   = miss || m_refill;
      e_stall = hz && !e_frz;
      e_fa    = v && dep(2, a);
      e_fb    = v && dep(2, b);
      conf    = m_ok || (!m_refill && hit);
      e_uns   = m_vld[0] && m_spec && !conf;
      e_rep   = m_rep && m_vld[0] && m_spec;
      chk(stall_rf,   e_stall, "R2", "stall_rf");
      chk(bubble_ex,  e_stall, "R2", "bubble_ex");
      chk(fwd_a,      e_fa,    "R4", "fwd_a");
      chk(fwd_b,      e_fb,    "R4", "fwd_b");
      chk(freeze_all, e_frz,   "R6", "freeze_all");
      chk(ex_unsafe,  e_uns,   "R8", "ex_unsafe");
      chk(replay_ex,  e_rep,   "R7", "replay_ex");
      if (m_refill) begin
         if (rd) begin m_refill = 0; m_ok = 1; m_rep = 1; end
      end else if (miss) begin
         m_refill = 1;
      end else begin
         for (int i = 3; i > 0; i--) begin m_vld[i] = m_vld[i-1]; m_ld[i] = m_ld[i-1]; end
         for (int i = 2; i > 0; i--) m_dst[i] = m_dst[i-1];
         m_vld[0] = v && !e_stall;
         m_ld[0]  = v && !e_stall && ld;
         m_dst[0] = dst;
         m_spec   = v && !e_stall && (e_fa || e_fb);
         m_ok = 0; m_rep = 0;
      end
   endtask

   task automatic nop(input bit hit);
      step(1'b1, 1'b0, 0, 0, 0, hit, 1'b0);
   endtask

   task automatic flush();
      for (int i = 0; i < 5; i++) nop(1'b1);
   endtask

   bit done = 0;

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_err++;
         $display("FAIL watchdog expired");
         $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
         $finish;
      end
   end

   initial begin
      bit cv, cl, ch, cr;
      int cd, ca, cb;
      void'($urandom(32'd4242));
      model_reset();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1: quiet after reset
      step(0, 0, 0, 0, 0, 0, 0);
      chk(stall_rf | bubble_ex | fwd_a | fwd_b | freeze_all | ex_unsafe | replay_ex,
          1'b0, "R1", "any output after reset");

      // R2: back-to-back dependency stalls two cycles
      flush();
      step(1, 1, 5, 1, 2, 1, 0);
      step(1, 0, 8, 5, 0, 1, 0); chk(stall_rf, 1, "R2", "first stall");
      step(1, 0, 8, 5, 0, 1, 0); chk(stall_rf, 1, "R2", "second stall");
      step(1, 0, 8, 5, 0, 1, 0); chk(stall_rf, 0, "R2", "released"); chk(fwd_a, 1, "R2", "fwd_a");
      nop(1);                    chk(ex_unsafe, 0, "R8", "hit confirmed");

      // R3: one instruction gap stalls one cycle
      flush();
      step(1, 1, 7, 0, 0, 1, 0);
      nop(1);
      step(1, 0, 9, 0, 7, 1, 0); chk(stall_rf, 1, "R3", "single stall");
      step(1, 0, 9, 0, 7, 1, 0); chk(stall_rf, 0, "R3", "released"); chk(fwd_b, 1, "R3", "fwd_b");

      // R5: index 0 and non-load producers
      flush();
      step(1, 1, 0, 0, 0, 1, 0);
      step(1, 0, 3, 0, 0, 1, 0); chk(stall_rf, 0, "R5", "r0 load");
      step(1, 0, 3, 1, 1, 1, 0);
      step(1, 0, 4, 3, 3, 1, 0); chk(stall_rf, 0, "R5", "non-load producer");

      // R4, R6, R7, R8: early consumer, then miss and replay
      flush();
      step(1, 1, 9, 0, 0, 1, 0);
      nop(1); nop(1);
      step(1, 0, 10, 9, 1, 1, 0); chk(stall_rf, 0, "R4", "no stall"); chk(fwd_a, 1, "R4", "fwd_a");
      nop(0); chk(freeze_all, 1, "R6", "miss freeze"); chk(ex_unsafe, 1, "R8", "unsafe on miss");
      nop(1); chk(freeze_all, 1, "R6", "hold 1");
      nop(0); chk(freeze_all, 1, "R6", "hold 2");
      step(1, 0, 0, 0, 0, 1, 1); chk(freeze_all, 1, "R6", "refill cycle");
      nop(1); chk(freeze_all, 0, "R6", "release"); chk(replay_ex, 1, "R7", "replay");
      chk(ex_unsafe, 0, "R8", "after refill");
      nop(1); chk(replay_ex, 0, "R7", "one pulse");

      // R4: gap of three, nothing
      flush();
      step(1, 1, 6, 0, 0, 1, 0);
      nop(1); nop(1); nop(1);
      step(1, 0, 2, 6, 6, 1, 0); chk(stall_rf | fwd_a | fwd_b, 0, "R4", "far consumer");

      // R9: miss without early consumer
      flush();
      step(1, 1, 4, 0, 0, 1, 0);
      nop(1); nop(1); nop(1);
      nop(0); chk(freeze_all, 1, "R9", "freeze"); chk(ex_unsafe, 0, "R9", "no unsafe");
      step(1, 0, 0, 0, 0, 1, 1);
      nop(1); chk(freeze_all, 0, "R9", "release"); chk(replay_ex, 0, "R9", "no replay");

      // R10: freeze during an owed stall keeps the owed count
      flush();
      step(1, 1, 2, 0, 0, 1, 0);
      nop(1); nop(1);
      step(1, 1, 6, 0, 0, 1, 0);
      step(1, 0, 11, 6, 0, 0, 0); chk(freeze_all, 1, "R10", "freeze"); chk(stall_rf, 0, "R10", "no stall in freeze");
      step(1, 0, 11, 6, 0, 1, 1);
      step(1, 0, 11, 6, 0, 1, 0); chk(stall_rf, 1, "R10", "owed stall 1");
      step(1, 0, 11, 6, 0, 1, 0); chk(stall_rf, 1, "R10", "owed stall 2");
      step(1, 0, 11, 6, 0, 1, 0); chk(stall_rf, 0, "R10", "done"); chk(fwd_a, 1, "R10", "fwd");

      // Random traffic; RF holds while the model predicts stall or freeze
      flush();
      cv = 0; cl = 0; cd = 0; ca = 0; cb = 0;
      for (int n = 0; n < 4000; n++) begin
         if (!(e_stall || e_frz)) begin
            cv = ($urandom % 8) != 0;
            cl = ($urandom % 3) == 0;
            cd = $urandom % 6; ca = $urandom % 6; cb = $urandom % 6;
         end
         ch = ($urandom % 100) < 85;
         cr = ($urandom % 4) == 0;
         step(cv, cl, cd, ca, cb, ch, cr);
      end

      done = 1;
      $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end
endmodule